// File: doc/BRIEF.md
# Cross-Domain Initialization Mode Handshake

This block lets a processor on a register (bus) clock ask a peripheral that runs on its own protocol clock to enter initialization mode, and tells the processor when that mode has been reached. Software writes a request bit in the bus domain. A two-flop synchronizer carries the bit into the protocol domain. There a mode flag is set, but only once no frame is being moved on the wire. The mode flag goes back to the bus domain through a second two-flop synchronizer and appears there as the acknowledge.

Software treats the acknowledge as the sign that initialization mode is active. The request bit cannot be cleared before that point. Leaving the mode runs the same path in reverse: the request is cleared, the protocol-side flag drops, and then the acknowledge drops. While the module enable is low the peripheral clocks count as stopped, so every register except the enable synchronizer holds its value.

Top module: `modereq_handshake`

## Requirements
- R1: The request bit reaches the protocol domain through a two-flop synchronizer. With `frame_busy` low, `init_mode` rises at the third `proto_clk` rising edge after the `bus_clk` edge that sets `init_req`, never earlier.
- R2: `init_ack` is `init_mode` passed through a two-flop synchronizer. It rises at the second `bus_clk` rising edge after `init_mode` rises, so entry costs at least two bus clocks plus three protocol clocks.
- R3: `init_ack` only rises while the request bit `init_req` is 1.
- R4: A write of 0 (`req_wr`=1, `req_wdata`=0) while `init_req`=1 and `init_ack`=0 is ignored. The same write takes effect when both `init_req` and `init_ack` are 1. A write of 1 always sets `init_req`.
- R5: While `frame_busy` is high and `init_mode` is 0, `init_mode` stays 0. Once `frame_busy` drops with the synchronized request already present, `init_mode` rises at the next `proto_clk` edge.
- R6: While `module_en` is 0, `init_req`, `init_ack` and `init_mode` hold their values and writes have no effect. In the protocol domain, `module_en` acts through its own two-flop synchronizer.
- R7: After reset in both domains, `init_req`, `init_ack` and `init_mode` are all 0.
- R8: Exit mirrors entry. After `init_req` is cleared, `init_mode` falls at the third `proto_clk` edge, whatever the state of `frame_busy`, and `init_ack` falls at the second `bus_clk` edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-side clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| module_en | input | 1 | Peripheral enable; 0 freezes the handshake |
| req_wr | input | 1 | Write strobe for the request bit |
| req_wdata | input | 1 | Value written to the request bit |
| init_req | output | 1 | Current request bit as software reads it back |
| init_ack | output | 1 | Acknowledge: initialization mode is active |
| proto_clk | input | 1 | Protocol-engine clock |
| proto_rst_n | input | 1 | Asynchronous active-low reset, protocol domain |
| frame_busy | input | 1 | High while a frame transfer is in progress |
| init_mode | output | 1 | Initialization mode flag in the protocol domain |

## Verification
The assertions assume that `req_wr`, `req_wdata` and `module_en` change only on the bus clock and that `frame_busy` changes only on the protocol clock. They also assume that each reset is held long enough to clear its whole domain. The bench drives bus-side inputs on `bus_clk` falling edges and `frame_busy` on `proto_clk` falling edges. The two clock periods are chosen so that no rising edge of one clock ever lines up with a rising edge of the other. This makes the synchronizer latency exact, so the bench can count it edge by edge.

// File: rtl/mhs_pkg.sv
package mhs_pkg;

  // Latency of the entry path, split by domain, for a given synchronizer depth.
  function automatic int entry_proto_edges(input int stages);
    return stages + 1;
  endfunction

  function automatic int entry_bus_edges(input int stages);
    return stages;
  endfunction

  // Software write rule for the request bit: set always, clear only once acknowledged.
  function automatic logic next_request(input logic cur, input logic wr,
                                        input logic wdata, input logic ack);
    logic nxt;
    nxt = cur;
    if (wr) begin
      if (wdata)            nxt = 1'b1;
      else if (cur && ack)  nxt = 1'b0;
    end
    return nxt;
  endfunction

  // Protocol-side mode flag: entry waits for an idle wire, exit does not.
  function automatic logic next_mode(input logic cur, input logic req_seen,
                                     input logic busy);
    logic nxt;
    if (!cur) nxt = req_seen && !busy;
    else      nxt = req_seen;
    return nxt;
  endfunction

endpackage

// File: rtl/mhs_sync.sv
module mhs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain[i] <= 1'b0;
        else if (adv) chain[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain[i] <= 1'b0;
        else if (adv) chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mhs_bus_ctrl.sv
module mhs_bus_ctrl
  import mhs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic req_wr,
  input  logic req_wdata,
  input  logic mode_async,
  output logic req_q,
  output logic ack
);
  logic req_d;

  assign req_d = next_request(req_q, req_wr, req_wdata, ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (enable) req_q <= req_d;
  end

  mhs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (enable),
    .d    (mode_async),
    .q    (ack)
  );
endmodule

// File: rtl/mhs_proto_ctrl.sv
module mhs_proto_ctrl
  import mhs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  input  logic req_async,
  input  logic busy,
  output logic mode,
  output logic en_s,
  output logic req_s
);
  logic mode_d;

  mhs_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (1'b1),
    .d    (en_async),
    .q    (en_s)
  );

  mhs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (en_s),
    .d    (req_async),
    .q    (req_s)
  );

  assign mode_d = next_mode(mode, req_s, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode <= 1'b0;
    else if (en_s) mode <= mode_d;
  end
endmodule

// File: rtl/modereq_handshake.sv
module modereq_handshake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic module_en,
  input  logic req_wr,
  input  logic req_wdata,
  output logic init_req,
  output logic init_ack,
  input  logic proto_clk,
  input  logic proto_rst_n,
  input  logic frame_busy,
  output logic init_mode
);
  // Named crossings, brought out for the checker.
  logic en_proto;
  logic req_proto;

  mhs_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk       (bus_clk),
    .rst_n     (bus_rst_n),
    .enable    (module_en),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .mode_async(init_mode),
    .req_q     (init_req),
    .ack       (init_ack)
  );

  mhs_proto_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_proto (
    .clk      (proto_clk),
    .rst_n    (proto_rst_n),
    .en_async (module_en),
    .req_async(init_req),
    .busy     (frame_busy),
    .mode     (init_mode),
    .en_s     (en_proto),
    .req_s    (req_proto)
  );
endmodule

// File: rtl/mhs_checker.sv
module mhs_checker (
  input logic bus_clk,
  input logic bus_rst_n,
  input logic module_en,
  input logic req_wr,
  input logic req_wdata,
  input logic init_req,
  input logic init_ack,
  input logic proto_clk,
  input logic proto_rst_n,
  input logic frame_busy,
  input logic init_mode,
  input logic en_proto,
  input logic req_proto
);
  p_early_clear_ignored_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (module_en && req_wr && !req_wdata && init_req && !init_ack) |=> init_req);

  p_ack_needs_request_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(init_ack) |-> init_req);

  p_bus_frozen_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !module_en |=> ($stable(init_req) && $stable(init_ack)));

  p_entry_deferred_r5: assert property (@(posedge proto_clk) disable iff (!proto_rst_n)
    (en_proto && !init_mode && frame_busy) |=> !init_mode);

  p_entry_after_sync_r1: assert property (@(posedge proto_clk) disable iff (!proto_rst_n)
    $rose(init_mode) |-> $past(req_proto));

  p_exit_after_sync_r8: assert property (@(posedge proto_clk) disable iff (!proto_rst_n)
    $fell(init_mode) |-> !$past(req_proto));

  p_proto_frozen_r6: assert property (@(posedge proto_clk) disable iff (!proto_rst_n)
    !en_proto |=> $stable(init_mode));
endmodule

bind modereq_handshake mhs_checker u_mhs_checker (
  .bus_clk    (bus_clk),
  .bus_rst_n  (bus_rst_n),
  .module_en  (module_en),
  .req_wr     (req_wr),
  .req_wdata  (req_wdata),
  .init_req   (init_req),
  .init_ack   (init_ack),
  .proto_clk  (proto_clk),
  .proto_rst_n(proto_rst_n),
  .frame_busy (frame_busy),
  .init_mode  (init_mode),
  .en_proto   (en_proto),
  .req_proto  (req_proto)
);

// File: tb/test_modereq_handshake.sv
`timescale 1ns/1ps
module test_modereq_handshake;
  logic bus_clk = 1'b0;
  logic proto_clk = 1'b0;
  logic bus_rst_n = 1'b0;
  logic proto_rst_n = 1'b0;
  logic module_en = 1'b0;
  logic req_wr = 1'b0;
  logic req_wdata = 1'b0;
  logic frame_busy = 1'b0;
  logic init_req, init_ack, init_mode;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // 50 MHz bus clock; protocol clock 14 ns, phase chosen so rising edges never coincide.
  always #10 bus_clk = ~bus_clk;
  initial begin
    #3;
    forever begin
      proto_clk = ~proto_clk;
      #7;
    end
  end

  modereq_handshake i_modereq_handshake (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .module_en  (module_en),
    .req_wr     (req_wr),
    .req_wdata  (req_wdata),
    .init_req   (init_req),
    .init_ack   (init_ack),
    .proto_clk  (proto_clk),
    .proto_rst_n(proto_rst_n),
    .frame_busy (frame_busy),
    .init_mode  (init_mode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive a one-cycle write; returns 0.2 ns after the edge that takes it.
  task automatic write_req(input logic v);
    @(negedge bus_clk);
    req_wr = 1'b1;
    req_wdata = v;
    @(posedge bus_clk);
    #0.2;
    req_wr = 1'b0;
  endtask

  // Count protocol edges until init_mode reaches lvl.
  task automatic count_proto(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge proto_clk);
      #0.2;
      n++;
      if (init_mode == lvl) break;
    end
  endtask

  // Count bus edges until init_ack reaches lvl.
  task automatic count_bus(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge bus_clk);
      #0.2;
      n++;
      if (init_ack == lvl) break;
    end
  endtask

  task automatic wait_bus(input int n);
    for (int i = 0; i < n; i++) @(posedge bus_clk);
    #0.2;
  endtask

  task automatic t_reset;
    check(init_req == 1'b0, "R7", "init_req after reset", int'(init_req), 0);
    check(init_ack == 1'b0, "R7", "init_ack after reset", int'(init_ack), 0);
    check(init_mode == 1'b0, "R7", "init_mode after reset", int'(init_mode), 0);
  endtask

  task automatic t_entry_latency;
    int np, nb;
    write_req(1'b1);
    count_proto(1'b1, np);
    check(np == 3, "R1", "proto edges to init_mode rise", np, 3);
    check(init_ack == 1'b0, "R2", "init_ack early", int'(init_ack), 0);
    count_bus(1'b1, nb);
    check(nb == 2, "R2", "bus edges to init_ack rise", nb, 2);
    check(init_req == 1'b1, "R3", "init_req when ack rose", int'(init_req), 1);
  endtask

  task automatic t_exit;
    int np, nb;
    write_req(1'b0);
    check(init_req == 1'b0, "R4", "clear after ack", int'(init_req), 0);
    count_proto(1'b0, np);
    check(np == 3, "R8", "proto edges to init_mode fall", np, 3);
    count_bus(1'b0, nb);
    check(nb == 2, "R8", "bus edges to init_ack fall", nb, 2);
  endtask

  task automatic t_early_clear;
    int nb;
    write_req(1'b1);
    write_req(1'b0);
    check(init_req == 1'b1, "R4", "early clear ignored", int'(init_req), 1);
    count_bus(1'b1, nb);
    check(init_ack == 1'b1, "R4", "ack still reached after early clear", int'(init_ack), 1);
    t_exit();
  endtask

  task automatic t_busy_defer;
    int np;
    @(negedge proto_clk);
    frame_busy = 1'b1;
    write_req(1'b1);
    for (int i = 0; i < 12; i++) @(posedge proto_clk);
    #0.2;
    check(init_mode == 1'b0, "R5", "mode held off while busy", int'(init_mode), 0);
    check(init_ack == 1'b0, "R5", "ack held off while busy", int'(init_ack), 0);
    @(negedge proto_clk);
    frame_busy = 1'b0;
    count_proto(1'b1, np);
    check(np == 1, "R5", "proto edges to mode after busy drops", np, 1);
    count_bus(1'b1, np);
    // Exit is not held by an active transfer.
    @(negedge proto_clk);
    frame_busy = 1'b1;
    t_exit();
    @(negedge proto_clk);
    frame_busy = 1'b0;
  endtask

  task automatic t_disabled;
    int nb;
    module_en = 1'b0;
    wait_bus(4);
    write_req(1'b1);
    wait_bus(10);
    check(init_req == 1'b0, "R6", "set ignored while disabled", int'(init_req), 0);
    check(init_mode == 1'b0, "R6", "mode frozen while disabled", int'(init_mode), 0);
    @(negedge bus_clk);
    module_en = 1'b1;
    write_req(1'b1);
    count_bus(1'b1, nb);
    check(init_ack == 1'b1, "R6", "ack after re-enable", int'(init_ack), 1);
    @(negedge bus_clk);
    module_en = 1'b0;
    wait_bus(4);
    write_req(1'b0);
    wait_bus(10);
    check(init_req == 1'b1, "R6", "clear ignored while disabled", int'(init_req), 1);
    check(init_ack == 1'b1, "R6", "ack frozen while disabled", int'(init_ack), 1);
    check(init_mode == 1'b1, "R6", "mode frozen while disabled", int'(init_mode), 1);
    @(negedge bus_clk);
    module_en = 1'b1;
    wait_bus(4);
    t_exit();
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #55;
    bus_rst_n = 1'b1;
    proto_rst_n = 1'b1;
    @(negedge bus_clk);
    t_reset();
    module_en = 1'b1;
    wait_bus(6);
    t_entry_latency();
    t_exit();
    wait_bus(3);
    t_early_clear();
    wait_bus(3);
    t_busy_defer();
    wait_bus(3);
    t_disabled();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule